// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This unit keeps the eight-bit status byte of a serial flash device and acts as the gatekeeper for every operation that can change stored data. The command engine sends it one-cycle request strobes. There are strobes for write enable, write disable, status write, page program, sector erase and chip erase, and each comes with a byte address and, for a status write, the new status byte. The unit checks each write-type request against three things: the write-enable latch, the protected address range chosen by the three block-protect bits, and the status-lock bit together with the active-low hardware protect pin.

An accepted operation produces a one-cycle grant pulse on a one-hot vector. The unit then stays busy for a self-timed number of clock cycles, and each operation type has its own parameter for that count. When the operation finishes, the write-enable latch clears. For a status write, the new protect bits take effect at that same moment. A rejected request leaves no trace. While the unit is busy it ignores every request, and only the status byte can be read. The array is eight sectors; the upper three address bits pick the sector.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte holds busy in bit 0, the write-enable latch in bit 1, block-protect bits P0, P1 and P2 in bits 2, 3 and 4, and the status-lock bit in bit 7. Bits 5 and 6 always read 0. After reset the whole byte is 0x00.
- R2: When the unit is idle, a write-enable strobe sets bit 1 in the following cycle and a write-disable strobe clears it. If both arrive together, disable wins.
- R3: A status write, program, sector erase or chip erase that arrives while bit 1 is 0 is rejected. It gives no grant and no busy, and the status byte does not change.
- R4: A status write is refused when bit 7 is 1 and wp_n is 0. When bit 7 is 0, wp_n has no effect on status writes.
- R5: An accepted status write copies bits 7, 4, 3 and 2 of wr_data into the status byte when it completes. Data bits 0, 1, 5 and 6 have no effect.
- R6: With P2..P0 = 000 nothing is protected. Code 001 protects the upper 1/8 of the array (address top three bits 111), code 010 the upper 1/4 (top two bits 11), code 011 the upper 1/2 (top bit 1), and any code with P2 = 1 protects everything. A program or sector erase aimed at a protected address is rejected.
- R7: A chip erase is rejected whenever P2..P0 is not 000.
- R8: An accepted request raises exactly one bit of grant for one cycle in the cycle after the strobe. The bit is 0 for status write, 1 for program, 2 for sector erase and 3 for chip erase. busy is high from that cycle for exactly T_WRSR, T_PROG, T_SERASE or T_CERASE cycles.
- R9: The write-enable latch reads 0 in the first cycle after any accepted operation ends.
- R10: While busy, every request strobe is ignored: no grant, and no change to bits 1 to 7.
- R11: When several write-type strobes arrive together, the unit handles only one of them, with priority status write, then program, then sector erase, then chip erase. Write enable and write disable are ignored in a cycle that carries any write-type strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Active-low hardware protect pin |
| req_wren | input | 1 | Write-enable strobe |
| req_wrdis | input | 1 | Write-disable strobe |
| req_wrsr | input | 1 | Status-write strobe |
| req_prog | input | 1 | Page-program strobe |
| req_serase | input | 1 | Sector-erase strobe |
| req_cerase | input | 1 | Chip-erase strobe |
| req_addr | input | ADDR_W | Target byte address |
| wr_data | input | 8 | New status byte for a status write |
| status | output | 8 | Status byte |
| busy | output | 1 | Self-timed operation in progress |
| grant | output | 4 | One-hot acceptance pulse per operation type |

## Verification
The bench aims at the edges of each protect range. These are the first and last address inside the upper 1/8, 1/4 and 1/2, and the address just below each one. A decoder that is off by one region would program into protected space or refuse a legal address. The bench sends a status write with the lock bit set while the pin is both low and high, to catch a lock that ignores the pin or ignores the bit. It sends a chip erase with only P0 set, which catches an erase check that only looks at the whole-array codes. It also sends write disable and program strobes in the middle of a busy period. A unit that let them through would show bit 1 dropping early or a second grant, and would stretch the busy count. Random traffic then mixes all six requests, with random data and random pin levels, against a reference model.

// File: rtl/fsg_pkg.sv
// Package fsg_pkg
// Shared operation codes and status-bit positions for the flash status guard.
// Assumes the bit positions are fixed by the status byte layout read by software.
package fsg_pkg;

    typedef enum logic [1:0] {
        OP_WRSR   = 2'd0,
        OP_PROG   = 2'd1,
        OP_SERASE = 2'd2,
        OP_CERASE = 2'd3
    } op_e;

    localparam int N_OPS     = 4;
    localparam int BIT_BUSY  = 0;
    localparam int BIT_WEL   = 1;
    localparam int BIT_P0    = 2;
    localparam int BIT_LOCK  = 7;
    localparam int SEC_BITS  = 3;

endpackage

// File: rtl/fsg_protect_decode.sv
// Module fsg_protect_decode
// Combinational check of an address against the protect code.
// Assumes an array of 2**SEC_BITS equal sectors addressed by the top bits;
// the code selects how many upper sectors (1, 2, 4 or all) are read-only.
module fsg_protect_decode
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [2:0]        prot,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_locked,
    output logic              any_locked
);
    localparam int TOP = ADDR_W - 1;

    logic [SEC_BITS-1:0] sec;

    assign sec = addr[TOP -: SEC_BITS];

    // Locked when the address falls inside the upper fraction selected by prot.
    always_comb begin
        unique case (prot)
            3'b000:  addr_locked = 1'b0;
            3'b001:  addr_locked = &sec;
            3'b010:  addr_locked = &sec[SEC_BITS-1 -: 2];
            3'b011:  addr_locked = sec[SEC_BITS-1];
            default: addr_locked = 1'b1;
        endcase
    end

    // Any nonzero code protects at least part of the array.
    assign any_locked = |prot;

endmodule

// File: rtl/fsg_admit.sv
// Module fsg_admit
// Decides, in the cycle a strobe arrives, whether it is accepted.
// Assumes strobes last one cycle; picks one write-type strobe by fixed
// priority and ignores everything while busy.
module fsg_admit
    import fsg_pkg::*;
(
    input  logic req_wren,
    input  logic req_wrdis,
    input  logic req_wrsr,
    input  logic req_prog,
    input  logic req_serase,
    input  logic req_cerase,
    input  logic busy,
    input  logic wel,
    input  logic lock_bit,
    input  logic wp_n,
    input  logic addr_locked,
    input  logic any_locked,
    output logic accept,
    output op_e  op,
    output logic set_wel,
    output logic clr_wel
);
    logic want;
    logic legal;

    assign want = req_wrsr | req_prog | req_serase | req_cerase;

    // Select the operation by priority and apply its own protection rule.
    always_comb begin
        op    = OP_CERASE;
        legal = !any_locked;
        if (req_wrsr) begin
            op    = OP_WRSR;
            legal = !(lock_bit && !wp_n);
        end else if (req_prog) begin
            op    = OP_PROG;
            legal = !addr_locked;
        end else if (req_serase) begin
            op    = OP_SERASE;
            legal = !addr_locked;
        end
    end

    // Accept only when idle, latch set and protection allows it.
    assign accept  = !busy && want && wel && legal;

    // Latch set/clear only when idle and no write-type strobe is present.
    assign clr_wel = !busy && !want && req_wrdis;
    assign set_wel = !busy && !want && req_wren && !req_wrdis;

endmodule

// File: rtl/fsg_busy_timer.sv
// Module fsg_busy_timer
// Self-timed busy counter loaded with the duration of the started operation.
// Assumes every duration parameter is at least 1 and that start only comes
// when idle.
module fsg_busy_timer
    import fsg_pkg::*;
#(
    parameter int T_WRSR   = 5,
    parameter int T_PROG   = 8,
    parameter int T_SERASE = 12,
    parameter int T_CERASE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  start_op,
    output logic busy,
    output logic done,
    output op_e  cur_op
);
    localparam int T_MAX_A = (T_WRSR > T_PROG) ? T_WRSR : T_PROG;
    localparam int T_MAX_B = (T_SERASE > T_CERASE) ? T_SERASE : T_CERASE;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    // Remaining-cycle value for the operation being started.
    always_comb begin
        unique case (start_op)
            OP_WRSR:   load_val = CNT_W'(T_WRSR - 1);
            OP_PROG:   load_val = CNT_W'(T_PROG - 1);
            OP_SERASE: load_val = CNT_W'(T_SERASE - 1);
            default:   load_val = CNT_W'(T_CERASE - 1);
        endcase
    end

    // Final busy cycle of the running operation.
    assign done = busy && (cnt == '0);

    // Load on start, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cur_op <= OP_WRSR;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt    <= load_val;
            cur_op <= start_op;
        end else if (done) begin
            busy   <= 1'b0;
        end else if (busy) begin
            cnt    <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/flash_status_guard.sv
// Module flash_status_guard
// Status byte and write guard for a serial flash command engine.
// Holds the latch, protect code and lock bit, admits write-type requests,
// times them and clears the latch on completion. Assumes single-cycle
// strobes from the command engine.
module flash_status_guard
    import fsg_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int T_WRSR   = 5,
    parameter int T_PROG   = 8,
    parameter int T_SERASE = 12,
    parameter int T_CERASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              req_wren,
    input  logic              req_wrdis,
    input  logic              req_wrsr,
    input  logic              req_prog,
    input  logic              req_serase,
    input  logic              req_cerase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        status,
    output logic              busy,
    output logic [3:0]        grant
);
    logic       wel;
    logic       lock_bit;
    logic [2:0] prot;
    logic [3:0] pend;
    logic       addr_locked;
    logic       any_locked;
    logic       accept;
    op_e        op;
    logic       set_wel;
    logic       clr_wel;
    logic       done;
    op_e        cur_op;

    fsg_protect_decode #(.ADDR_W(ADDR_W)) u_dec (
        .prot        (prot),
        .addr        (req_addr),
        .addr_locked (addr_locked),
        .any_locked  (any_locked)
    );

    fsg_admit u_admit (
        .req_wren    (req_wren),
        .req_wrdis   (req_wrdis),
        .req_wrsr    (req_wrsr),
        .req_prog    (req_prog),
        .req_serase  (req_serase),
        .req_cerase  (req_cerase),
        .busy        (busy),
        .wel         (wel),
        .lock_bit    (lock_bit),
        .wp_n        (wp_n),
        .addr_locked (addr_locked),
        .any_locked  (any_locked),
        .accept      (accept),
        .op          (op),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel)
    );

    fsg_busy_timer #(
        .T_WRSR   (T_WRSR),
        .T_PROG   (T_PROG),
        .T_SERASE (T_SERASE),
        .T_CERASE (T_CERASE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_op (op),
        .busy     (busy),
        .done     (done),
        .cur_op   (cur_op)
    );

    // One-hot grant pulse, one per operation type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else begin
            grant <= '0;
            for (int i = 0; i < N_OPS; i++) begin
                if (accept && (op == op_e'(i))) begin
                    grant[i] <= 1'b1;
                end
            end
        end
    end

    // Capture the writable status bits when a status write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (accept && op == OP_WRSR) begin
            pend <= {wr_data[BIT_LOCK], wr_data[BIT_P0+2:BIT_P0]};
        end
    end

    // Latch and protect bits: completion clears the latch and commits data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel      <= 1'b0;
            lock_bit <= 1'b0;
            prot     <= 3'b000;
        end else if (done) begin
            wel <= 1'b0;
            if (cur_op == OP_WRSR) begin
                lock_bit <= pend[3];
                prot     <= pend[2:0];
            end
        end else if (clr_wel) begin
            wel <= 1'b0;
        end else if (set_wel) begin
            wel <= 1'b1;
        end
    end

    // Assemble the status byte; bits 5 and 6 are constant zero.
    assign status = {lock_bit, 2'b00, prot, wel, busy};

endmodule

// File: rtl/fsg_checker.sv
// Module fsg_checker
// Property checker for flash_status_guard, attached with bind.
// Measures each busy window with its own counter.
module fsg_checker
    import fsg_pkg::*;
#(
    parameter int T_WRSR   = 5,
    parameter int T_PROG   = 8,
    parameter int T_SERASE = 12,
    parameter int T_CERASE = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic [7:0] status,
    input logic       busy,
    input logic [3:0] grant
);
    logic [15:0] run;
    logic [3:0]  run_op;
    logic [15:0] exp_len;

    // Count busy cycles of the operation that was last granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= '0;
            run_op <= '0;
        end else if (|grant) begin
            run    <= 16'd1;
            run_op <= grant;
        end else if (busy) begin
            run    <= run + 16'd1;
        end
    end

    // Expected length for the granted operation.
    always_comb begin
        unique case (run_op)
            4'b0001: exp_len = 16'(T_WRSR);
            4'b0010: exp_len = 16'(T_PROG);
            4'b0100: exp_len = 16'(T_SERASE);
            default: exp_len = 16'(T_CERASE);
        endcase
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00);

    p_busy_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == busy);

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_starts_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (busy && !$past(busy)));

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == exp_len));

    p_grant_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> $past(status[1]));

    p_lock_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> !($past(status[7]) && !$past(wp_n)));

    p_cerase_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant[3] |-> ($past(status[4:2]) == 3'b000));

    p_wel_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);

    p_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(status[7:1]) && grant == 4'b0000));

endmodule

bind flash_status_guard fsg_checker #(
    .T_WRSR   (T_WRSR),
    .T_PROG   (T_PROG),
    .T_SERASE (T_SERASE),
    .T_CERASE (T_CERASE)
) u_fsg_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .wp_n   (wp_n),
    .status (status),
    .busy   (busy),
    .grant  (grant)
);

// File: tb/tb_flash_status_guard.sv
module tb_flash_status_guard;

    localparam int AW  = 19;
    localparam int TWS = 5;
    localparam int TPP = 8;
    localparam int TSE = 12;
    localparam int TCE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          req_wren = 1'b0, req_wrdis = 1'b0, req_wrsr = 1'b0;
    logic          req_prog = 1'b0, req_serase = 1'b0, req_cerase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    status;
    logic          busy;
    logic [3:0]    grant;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic       m_wel = 1'b0;
    logic       m_lock = 1'b0;
    logic [2:0] m_prot = 3'b000;

    always #4 clk = ~clk;

    flash_status_guard #(
        .ADDR_W(AW), .T_WRSR(TWS), .T_PROG(TPP), .T_SERASE(TSE), .T_CERASE(TCE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .req_wren(req_wren), .req_wrdis(req_wrdis), .req_wrsr(req_wrsr),
        .req_prog(req_prog), .req_serase(req_serase), .req_cerase(req_cerase),
        .req_addr(req_addr), .wr_data(wr_data),
        .status(status), .busy(busy), .grant(grant)
    );

    function automatic logic in_prot(input logic [2:0] p, input logic [AW-1:0] a);
        logic [2:0] s;
        s = a[AW-1 -: 3];
        case (p)
            3'b000: return 1'b0;
            3'b001: return s == 3'b111;
            3'b010: return s[2:1] == 2'b11;
            3'b011: return s[2];
            default: return 1'b1;
        endcase
    endfunction

    function automatic int dur_of(input int kind);
        case (kind)
            2: return TWS;
            3: return TPP;
            4: return TSE;
            default: return TCE;
        endcase
    endfunction

    function automatic logic [7:0] m_status();
        return {m_lock, 2'b00, m_prot, m_wel, 1'b0};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int kind, input logic v);
        case (kind)
            0: req_wren = v;
            1: req_wrdis = v;
            2: req_wrsr = v;
            3: req_prog = v;
            4: req_serase = v;
            default: req_cerase = v;
        endcase
    endtask

    // kinds: 0 wren, 1 wrdis, 2 status write, 3 program, 4 sector erase, 5 chip erase
    task automatic do_op(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic pin, input string tag);
        logic acc;
        int   cnt;
        @(negedge clk);
        wp_n = pin; req_addr = a; wr_data = d;
        drive(kind, 1'b1);
        acc = 1'b0;
        case (kind)
            2: acc = m_wel && !(m_lock && !pin);
            3, 4: acc = m_wel && !in_prot(m_prot, a);
            5: acc = m_wel && (m_prot == 3'b000);
            default: acc = 1'b0;
        endcase
        @(negedge clk);
        drive(kind, 1'b0);
        if (kind < 2) begin
            m_wel = (kind == 0);
            chk(busy == 1'b0 && grant == 4'b0, tag, {busy, grant}, 0);
            chk(status == m_status(), tag, status, m_status());
        end else if (acc) begin
            chk(grant == (4'b1 << (kind - 2)), tag, grant, 4'b1 << (kind - 2));
            cnt = 0;
            while (busy && cnt < 1000) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == dur_of(kind), "R8", cnt, dur_of(kind));
            m_wel = 1'b0;
            if (kind == 2) begin
                m_lock = d[7];
                m_prot = d[4:2];
            end
            chk(status == m_status(), tag, status, m_status());
        end else begin
            chk(grant == 4'b0 && busy == 1'b0, tag, {busy, grant}, 0);
            chk(status == m_status(), tag, status, m_status());
        end
    endtask

    // Watchdog: expiry counts as a failed check.
    initial begin
        #1600000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 8'h00 && busy == 1'b0 && grant == 4'b0, "R1 reset", status, 0);

        // R3: no latch -> rejected
        do_op(3, '0, 8'h00, 1'b1, "R3 prog no latch");
        do_op(2, '0, 8'h9C, 1'b1, "R3 wrsr no latch");
        // R2
        do_op(0, '0, 8'h00, 1'b1, "R2 wren");
        do_op(1, '0, 8'h00, 1'b1, "R2 wrdis");
        // R5: writes only bits 7,4,3,2 (lock off)
        do_op(0, '0, 8'h00, 1'b1, "R2 wren");
        do_op(2, '0, 8'h67, 1'b0, "R5 wrsr masked");
        chk(status == 8'h04, "R5 value", status, 8'h04);
        // R6 boundaries at code 001
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(3, 19'h70000, 0, 1'b1, "R6 upper1/8 first");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(3, 19'h6FFFF, 0, 1'b1, "R6 below 1/8");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(4, 19'h7FFFF, 0, 1'b1, "R6 erase last");
        // R7: chip erase with code 001
        do_op(5, '0, 0, 1'b1, "R7 cerase partial");
        // code 010 then 011
        do_op(2, '0, 8'h08, 1'b1, "R5 code010");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(3, 19'h5FFFF, 0, 1'b1, "R6 below 1/4");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(3, 19'h60000, 0, 1'b1, "R6 in 1/4");
        do_op(2, '0, 8'h0C, 1'b1, "R5 code011");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(3, 19'h40000, 0, 1'b1, "R6 in 1/2");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(4, 19'h3FFFF, 0, 1'b1, "R6 below 1/2");
        // R4: lock set, pin low refused, pin high allowed
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(2, '0, 8'h90, 1'b1, "R4 set lock");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(2, '0, 8'h00, 1'b0, "R4 locked pin low");
        do_op(2, '0, 8'h00, 1'b1, "R4 pin high");
        do_op(0, '0, 0, 1'b1, "R2");
        do_op(5, '0, 0, 1'b0, "R7 cerase clear");

        // R10/R11: strobes during busy, and simultaneous strobes
        do_op(0, '0, 0, 1'b1, "R2");
        @(negedge clk);
        req_prog = 1'b1; req_cerase = 1'b1; req_wrdis = 1'b1; req_addr = '0;
        @(negedge clk);
        req_prog = 1'b0; req_cerase = 1'b0; req_wrdis = 1'b0;
        chk(grant == 4'b0010 && status[1] == 1'b1, "R11 priority", {status[1], grant}, 5'h12);
        @(negedge clk);
        req_wrdis = 1'b1; req_cerase = 1'b1;
        @(negedge clk);
        req_wrdis = 1'b0; req_cerase = 1'b0;
        chk(status[1] == 1'b1 && grant == 4'b0, "R10 ignore busy", {status[1], grant}, 5'h10);
        cnt = 2;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == TPP, "R10 length", cnt, TPP);
        chk(status[1] == 1'b0, "R9 wel clear", status, 0);
        m_wel = 1'b0;

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int r;
            int k;
            string tg;
            r = $urandom_range(0, 9);
            k = (r < 3) ? 0 : (r == 3) ? 1 : (r < 6) ? 2 : (r < 8) ? 3 : (r == 8) ? 4 : 5;
            if (k == 0) tg = "R2 rnd";
            else if (k == 1) tg = "R2 rnd dis";
            else if (!m_wel) tg = "R3 rnd";
            else if (k == 2) tg = "R4 rnd";
            else if (k == 5) tg = "R7 rnd";
            else tg = "R6 rnd";
            do_op(k, AW'($urandom), 8'($urandom), 1'($urandom), tg);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule